// File: doc/BRIEF.md
# Disk frame tick counter

This block sits on a stream of 32-bit recorded data words organised into disk frames. A frame begins with a header, and the source marks the first word of each frame with a start strobe. The block counts whole frames against a programmable, one-based frames-per-second value. When the count completes, the block does three things on the time-code word of that frame, which is header word 1:

- it captures the word,
- it increments a 16-bit tick counter,
- it raises a single-cycle tick interrupt request.

Every accepted word is also compared against two programmable 32-bit invalid-data patterns. One pattern belongs to the recorder and one to the host interface. Each pattern drives its own match strobe. A sticky header-error flag reports a frame that started before the previous frame reached its last word.

The settings are loaded through a narrow write port, 16 bits at a time, and are read back on dedicated outputs. A global enable freezes all stream-side state while it is low.

Top module: `dfrm_tick_top`

## Requirements
- R1: After reset the outputs are as follows. The tick counter, the captured time code, the tick request, both match strobes and the header-error flag are 0. The frames-per-second value is 0x100. The recorder pattern is 0x00AA_0055 and the interface pattern is 0x00CC_0033.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the field chosen by `cfg_sel`. The encodings are:
  - 0: recorder pattern bits 15:0
  - 1: recorder pattern bits 31:16
  - 2: interface pattern bits 15:0
  - 3: interface pattern bits 31:16
  - 4: frames-per-second, taken from bits 14:0

  Select codes 5 to 7 change nothing.
- R3: With a frames-per-second value N ≥ 1, a tick fires on every Nth accepted frame start. The tick is tied to the accepted word of that frame whose index is 1. A value of 0 behaves as 1.
- R4: On a tick, `tcode` takes the full data word of header word 1 in the same cycle as the tick request. It is captured unchanged even when the word equals an invalid pattern. `tcode` holds its value in every other cycle.
- R5: `tick_cnt` increments by one on each tick and wraps from 0xFFFF to 0.
- R6: `rec_match` and `ifc_match` are high for one cycle after an accepted word that equals all 32 bits of the recorder or interface pattern respectively. Each strobe is independent of the other, and a word differing in any bit gives no strobe.
- R7: `hdr_err` is set when an accepted frame start follows an earlier frame whose last accepted word index was not FRAME_WORDS-1. It stays set until reset.
- R8: While `en` is low, stream words have no effect. The tick counter, the time code, the frame count and the header-error flag hold, and no tick or match strobe is produced.
- R9: `tick_irq` is a one-cycle pulse, registered one cycle after the time-code word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Stream-side enable |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 3 | Setting field select |
| cfg_wdata | input | 16 | Setting write data |
| word_vld | input | 1 | Stream word valid |
| frame_start | input | 1 | Marks the first word of a frame (valid with word_vld) |
| word_idx | input | 4 | Index of the word inside its frame |
| word | input | 32 | Stream data word |
| fps_q | output | 15 | Frames-per-second setting |
| rec_pat_q | output | 32 | Recorder invalid pattern |
| ifc_pat_q | output | 32 | Interface invalid pattern |
| tcode | output | 32 | Captured time-code word |
| tick_cnt | output | 16 | Tick counter |
| tick_irq | output | 1 | Tick interrupt pulse |
| rec_match | output | 1 | Recorder pattern match strobe |
| ifc_match | output | 1 | Interface pattern match strobe |
| hdr_err | output | 1 | Sticky header-error flag |

## Verification
The assertions take `frame_start` to be meaningful only together with `word_vld`. They also take the time-code word to arrive at least one accepted word after its frame start. That spacing is what keeps two tick pulses from touching.

The pattern-match properties compare against the pattern outputs as they were in the cycle of the word, so they assume no setting write races the word being checked. The stimulus keeps to these assumptions in three ways:
- it always drives the start strobe together with a valid word at index 0;
- it places the time-code word directly after the start word;
- it changes settings only between stream words.

// File: rtl/dfrm_pkg.sv
package dfrm_pkg;

   localparam int unsigned NPAT = 2;

   typedef enum logic [2:0] {
      SEL_REC_LO = 3'd0,
      SEL_REC_HI = 3'd1,
      SEL_IFC_LO = 3'd2,
      SEL_IFC_HI = 3'd3,
      SEL_FPS    = 3'd4
   } cfg_sel_e;

   localparam logic [31:0] REC_PAT_RST = 32'h00AA_0055;
   localparam logic [31:0] IFC_PAT_RST = 32'h00CC_0033;
   localparam logic [15:0] FPS_RST     = 16'h0100;

   function automatic logic [31:0] pat_reset(input int unsigned p);
      return (p == 0) ? REC_PAT_RST : IFC_PAT_RST;
   endfunction

endpackage

// File: rtl/dfrm_cfg_regs.sv
module dfrm_cfg_regs
   import dfrm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CFG_W  = 16,
   parameter int unsigned FPS_W  = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [2:0]                   cfg_sel,
   input  logic [CFG_W-1:0]             cfg_wdata,
   output logic [FPS_W-1:0]             fps_q,
   output logic [NPAT-1:0][DATA_W-1:0]  pat_q
);

   localparam int unsigned HI_W = DATA_W - CFG_W;

   if (DATA_W != 2 * CFG_W) begin : g_bad_split
      $error("dfrm_cfg_regs: DATA_W must be twice CFG_W");
   end
   if (FPS_W > CFG_W) begin : g_bad_fps
      $error("dfrm_cfg_regs: FPS_W must fit in one write");
   end

   for (genvar p = 0; p < NPAT; p++) begin : g_pat
      localparam logic [DATA_W-1:0] RST    = DATA_W'(pat_reset(p));
      localparam logic [2:0]        SEL_LO = 3'(2 * p);
      localparam logic [2:0]        SEL_HI = 3'(2 * p + 1);
      logic [DATA_W-1:0] pat_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pat_r <= RST;
         end else if (cfg_we) begin
            if (cfg_sel == SEL_LO) pat_r[CFG_W-1:0]      <= cfg_wdata;
            if (cfg_sel == SEL_HI) pat_r[DATA_W-1:CFG_W] <= HI_W'(cfg_wdata);
         end
      end

      assign pat_q[p] = pat_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fps_q <= FPS_W'(FPS_RST);
      end else if (cfg_we && cfg_sel == SEL_FPS) begin
         fps_q <= cfg_wdata[FPS_W-1:0];
      end
   end

endmodule

// File: rtl/dfrm_pat_match.sv
module dfrm_pat_match
   import dfrm_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         word_vld,
   input  logic [DATA_W-1:0]            word,
   input  logic [NPAT-1:0][DATA_W-1:0]  pat,
   output logic [NPAT-1:0]              hit
);

   for (genvar p = 0; p < NPAT; p++) begin : g_cmp
      logic hit_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_r <= 1'b0;
         else        hit_r <= en & word_vld & (word == pat[p]);
      end

      assign hit[p] = hit_r;
   end

endmodule

// File: rtl/dfrm_frame_track.sv
module dfrm_frame_track #(
   parameter int unsigned FPS_W       = 15,
   parameter int unsigned FRAME_WORDS = 16,
   parameter int unsigned TC_IDX      = 1,
   parameter bit          CHECK_END   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic                           word_vld,
   input  logic                           frame_start,
   input  logic [$clog2(FRAME_WORDS)-1:0] word_idx,
   input  logic [FPS_W-1:0]               fps,
   output logic                           tick_hit,
   output logic                           hdr_err
);

   localparam int unsigned IDX_W = $clog2(FRAME_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
   localparam logic [IDX_W-1:0] TC_POS   = IDX_W'(TC_IDX);

   if (FRAME_WORDS < 2) begin : g_bad_len
      $error("dfrm_frame_track: a frame needs at least two words");
   end
   if (TC_IDX == 0 || TC_IDX >= FRAME_WORDS) begin : g_bad_tc
      $error("dfrm_frame_track: time-code word must follow the start word");
   end

   logic                 acc;
   logic [FPS_W-1:0]     fcnt;
   logic [FPS_W:0]       fcnt_nxt;
   logic                 armed;
   logic                 have_frame;
   logic [IDX_W-1:0]     last_idx;
   logic                 err_r;
   logic                 short_frame;

   assign acc      = en & word_vld;
   assign fcnt_nxt = {1'b0, fcnt} + (FPS_W + 1)'(1);

   if (CHECK_END) begin : g_end_chk
      assign short_frame = have_frame & (last_idx != LAST_IDX);
   end else begin : g_no_end_chk
      assign short_frame = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt       <= '0;
         armed      <= 1'b0;
         have_frame <= 1'b0;
         last_idx   <= '0;
         err_r      <= 1'b0;
      end else if (acc) begin
         last_idx <= word_idx;
         if (frame_start) begin
            have_frame <= 1'b1;
            if (short_frame) err_r <= 1'b1;
            if (fcnt_nxt >= {1'b0, fps}) begin
               fcnt  <= '0;
               armed <= 1'b1;
            end else begin
               fcnt  <= fcnt_nxt[FPS_W-1:0];
               armed <= 1'b0;
            end
         end else if (word_idx == TC_POS) begin
            armed <= 1'b0;
         end
      end
   end

   assign tick_hit = acc & ~frame_start & armed & (word_idx == TC_POS);
   assign hdr_err  = err_r;

endmodule

// File: rtl/dfrm_tick_capture.sv
module dfrm_tick_capture #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] tcode,
   output logic [TICK_W-1:0] tick_cnt,
   output logic              tick_irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcode    <= '0;
         tick_cnt <= '0;
         tick_irq <= 1'b0;
      end else begin
         tick_irq <= hit;
         if (hit) begin
            tcode    <= word;
            tick_cnt <= tick_cnt + TICK_W'(1);
         end
      end
   end

endmodule

// File: rtl/dfrm_tick_top.sv
module dfrm_tick_top
   import dfrm_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CFG_W       = 16,
   parameter int unsigned FPS_W       = 15,
   parameter int unsigned TICK_W      = 16,
   parameter int unsigned FRAME_WORDS = 16,
   parameter int unsigned TC_IDX      = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en,
   input  logic                           cfg_we,
   input  logic [2:0]                     cfg_sel,
   input  logic [CFG_W-1:0]               cfg_wdata,
   input  logic                           word_vld,
   input  logic                           frame_start,
   input  logic [$clog2(FRAME_WORDS)-1:0] word_idx,
   input  logic [DATA_W-1:0]              word,
   output logic [FPS_W-1:0]               fps_q,
   output logic [DATA_W-1:0]              rec_pat_q,
   output logic [DATA_W-1:0]              ifc_pat_q,
   output logic [DATA_W-1:0]              tcode,
   output logic [TICK_W-1:0]              tick_cnt,
   output logic                           tick_irq,
   output logic                           rec_match,
   output logic                           ifc_match,
   output logic                           hdr_err
);

   logic [NPAT-1:0][DATA_W-1:0] pat_q;
   logic [NPAT-1:0]             pat_hit;
   logic                        tick_hit;

   dfrm_cfg_regs #(
      .DATA_W (DATA_W),
      .CFG_W  (CFG_W),
      .FPS_W  (FPS_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .fps_q     (fps_q),
      .pat_q     (pat_q)
   );

   dfrm_pat_match #(
      .DATA_W (DATA_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .word_vld (word_vld),
      .word     (word),
      .pat      (pat_q),
      .hit      (pat_hit)
   );

   dfrm_frame_track #(
      .FPS_W       (FPS_W),
      .FRAME_WORDS (FRAME_WORDS),
      .TC_IDX      (TC_IDX),
      .CHECK_END   (1'b1)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .word_vld    (word_vld),
      .frame_start (frame_start),
      .word_idx    (word_idx),
      .fps         (fps_q),
      .tick_hit    (tick_hit),
      .hdr_err     (hdr_err)
   );

   dfrm_tick_capture #(
      .DATA_W (DATA_W),
      .TICK_W (TICK_W)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (tick_hit),
      .word     (word),
      .tcode    (tcode),
      .tick_cnt (tick_cnt),
      .tick_irq (tick_irq)
   );

   assign rec_pat_q = pat_q[0];
   assign ifc_pat_q = pat_q[1];
   assign rec_match = pat_hit[0];
   assign ifc_match = pat_hit[1];

endmodule

// File: rtl/dfrm_tick_chk.sv
module dfrm_tick_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TICK_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              word_vld,
   input logic [DATA_W-1:0] word,
   input logic [DATA_W-1:0] rec_pat_q,
   input logic [DATA_W-1:0] ifc_pat_q,
   input logic [DATA_W-1:0] tcode,
   input logic [TICK_W-1:0] tick_cnt,
   input logic              tick_irq,
   input logic              rec_match,
   input logic              ifc_match,
   input logic              hdr_err
);

   // R9: the tick request never lasts two cycles
   a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);

   // R5: each tick advances the counter by one, modulo full scale
   a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> tick_cnt == $past(tick_cnt) + TICK_W'(1));

   // R5: without a tick the counter holds
   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_irq |-> $stable(tick_cnt));

   // R4: the time code changes only together with a tick
   a_r4_tcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_irq |-> $stable(tcode));

   // R7: the header error is sticky
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |=> hdr_err);

   // R6: a recorder strobe follows an accepted word equal to the recorder pattern
   a_r6_rec_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rec_match |-> $past(en && word_vld && (word == rec_pat_q)));

   // R6: an interface strobe follows an accepted word equal to the interface pattern
   a_r6_ifc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ifc_match |-> $past(en && word_vld && (word == ifc_pat_q)));

   // R8: with the enable low in the previous cycle, no strobe appears
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (!tick_irq && !rec_match && !ifc_match));

endmodule

bind dfrm_tick_top dfrm_tick_chk #(
   .DATA_W (DATA_W),
   .TICK_W (TICK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .word_vld  (word_vld),
   .word      (word),
   .rec_pat_q (rec_pat_q),
   .ifc_pat_q (ifc_pat_q),
   .tcode     (tcode),
   .tick_cnt  (tick_cnt),
   .tick_irq  (tick_irq),
   .rec_match (rec_match),
   .ifc_match (ifc_match),
   .hdr_err   (hdr_err)
);

// File: tb/dfrm_tick_top_bench.sv
module dfrm_tick_top_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en;
   logic        cfg_we;
   logic [2:0]  cfg_sel;
   logic [15:0] cfg_wdata;
   logic        word_vld;
   logic        frame_start;
   logic [3:0]  word_idx;
   logic [31:0] word;
   logic [14:0] fps_q;
   logic [31:0] rec_pat_q, ifc_pat_q, tcode;
   logic [15:0] tick_cnt;
   logic        tick_irq, rec_match, ifc_match, hdr_err;

   int total = 0;
   int fails = 0;
   int cyc   = 0;
   bit done  = 1'b0;
   int exp_cnt;

   always #4 clk = ~clk;

   dfrm_tick_top u_dfrm_tick_top (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .word_vld(word_vld), .frame_start(frame_start),
      .word_idx(word_idx), .word(word), .fps_q(fps_q), .rec_pat_q(rec_pat_q),
      .ifc_pat_q(ifc_pat_q), .tcode(tcode), .tick_cnt(tick_cnt),
      .tick_irq(tick_irq), .rec_match(rec_match), .ifc_match(ifc_match),
      .hdr_err(hdr_err)
   );

   // data word, expected recorder strobe, expected interface strobe
   localparam logic [33:0] VEC [7] = '{
      {32'hDEAD_BEEF, 2'b10},
      {32'h00CC_0033, 2'b01},
      {32'hDEAD_BEEE, 2'b00},
      {32'h00CC_0032, 2'b00},
      {32'h5EAD_BEEF, 2'b00},
      {32'hFFFF_FFFF, 2'b00},
      {32'h0000_0000, 2'b00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic fs, input logic [3:0] idx, input logic [31:0] d);
      word_vld    = 1'b1;
      frame_start = fs;
      word_idx    = idx;
      word        = d;
      @(negedge clk);
      word_vld    = 1'b0;
      frame_start = 1'b0;
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [15:0] v);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic tail();
      for (int i = 2; i < 16; i++) put(1'b0, 4'(i), 32'h0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; en = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      word_vld = 1'b0; frame_start = 1'b0; word_idx = '0; word = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 195000 && !done) begin
         fails++; total++;
         $display("FAIL watchdog actual=%0d expected=<195000", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 fps", 32'(fps_q), 32'h100);
      chk("R1 rec_pat", rec_pat_q, 32'h00AA_0055);
      chk("R1 ifc_pat", ifc_pat_q, 32'h00CC_0033);
      chk("R1 tick_cnt", 32'(tick_cnt), 32'h0);
      chk("R1 tcode", tcode, 32'h0);
      chk("R1 strobes", {28'h0, tick_irq, rec_match, ifc_match, hdr_err}, 32'h0);

      // R2 setting writes
      cfg(3'd4, 16'h8003);
      cfg(3'd0, 16'hBEEF);
      cfg(3'd1, 16'hDEAD);
      chk("R2 fps", 32'(fps_q), 32'h3);
      chk("R2 rec_pat", rec_pat_q, 32'hDEAD_BEEF);
      cfg(3'd2, 16'h1234);
      cfg(3'd3, 16'h5678);
      chk("R2 ifc_pat", ifc_pat_q, 32'h5678_1234);
      cfg(3'd2, 16'h0033);
      cfg(3'd3, 16'h00CC);
      cfg(3'd7, 16'hFFFF);
      cfg(3'd5, 16'hFFFF);
      chk("R2 unused sel fps", 32'(fps_q), 32'h3);
      chk("R2 unused sel rec", rec_pat_q, 32'hDEAD_BEEF);
      chk("R2 unused sel ifc", ifc_pat_q, 32'h00CC_0033);

      // R6 pattern table (en is still low: R8 first)
      put(1'b0, 4'd2, 32'hDEAD_BEEF);
      chk("R8 no match when disabled", {30'h0, rec_match, ifc_match}, 32'h0);
      en = 1'b1;
      for (int i = 0; i < 7; i++) begin
         put(1'b0, 4'd2, VEC[i][33:2]);
         chk("R6 rec_match", 32'(rec_match), 32'(VEC[i][1]));
         chk("R6 ifc_match", 32'(ifc_match), 32'(VEC[i][0]));
      end
      @(negedge clk);
      chk("R6 strobe single cycle", {30'h0, rec_match, ifc_match}, 32'h0);

      // R3/R4/R9 with fps=3
      exp_cnt = 0;
      for (int f = 1; f <= 9; f++) begin
         logic [31:0] tc;
         tc = (f == 9) ? 32'hDEAD_BEEF : 32'h1000_0000 + 32'(f);
         put(1'b1, 4'd0, 32'h1);
         put(1'b0, 4'd1, tc);
         if (f % 3 == 0) begin
            exp_cnt++;
            chk("R3 tick on third frame", 32'(tick_irq), 32'h1);
            chk("R4 tcode captured", tcode, tc);
            chk("R5 tick_cnt", 32'(tick_cnt), 32'(exp_cnt));
         end else begin
            chk("R3 no tick", 32'(tick_irq), 32'h0);
         end
         if (f == 9) chk("R4 pattern word captured, R6 strobe", 32'(rec_match), 32'h1);
         put(1'b0, 4'd2, 32'h0);
         chk("R9 irq dropped", 32'(tick_irq), 32'h0);
         for (int i = 3; i < 16; i++) put(1'b0, 4'(i), 32'h0);
      end
      chk("R4 tcode held", tcode, 32'hDEAD_BEEF);
      chk("R7 no error on full frames", 32'(hdr_err), 32'h0);

      // R8 enable low
      en = 1'b0;
      for (int f = 0; f < 4; f++) begin
         put(1'b1, 4'd0, 32'h1);
         put(1'b0, 4'd1, 32'h00CC_0033);
         chk("R8 no tick or match", {30'h0, tick_irq, ifc_match}, 32'h0);
      end
      chk("R8 tick_cnt held", 32'(tick_cnt), 32'(exp_cnt));
      chk("R8 tcode held", tcode, 32'hDEAD_BEEF);
      chk("R8 hdr_err held", 32'(hdr_err), 32'h0);
      en = 1'b1;
      // frame count held at 0: three frames to the next tick
      for (int f = 1; f <= 3; f++) begin
         put(1'b1, 4'd0, 32'h1);
         put(1'b0, 4'd1, 32'h2000_0000 + 32'(f));
         chk("R8 frame count held", 32'(tick_irq), (f == 3) ? 32'h1 : 32'h0);
         tail();
      end
      exp_cnt++;

      // R3 fps=0 behaves as 1
      cfg(3'd4, 16'h0000);
      for (int f = 0; f < 2; f++) begin
         put(1'b1, 4'd0, 32'h1);
         put(1'b0, 4'd1, 32'h3000_0000 + 32'(f));
         exp_cnt++;
         chk("R3 fps0 tick each frame", 32'(tick_irq), 32'h1);
         chk("R5 tick_cnt fps0", 32'(tick_cnt), 32'(exp_cnt));
         tail();
      end

      // R7 short frame then a new start
      put(1'b1, 4'd0, 32'h1);
      put(1'b0, 4'd1, 32'h4000_0000);
      chk("R7 no error yet", 32'(hdr_err), 32'h0);
      put(1'b1, 4'd0, 32'h1);
      chk("R7 error set", 32'(hdr_err), 32'h1);
      put(1'b0, 4'd1, 32'h4000_0001);
      tail();
      put(1'b1, 4'd0, 32'h1);
      chk("R7 error sticky", 32'(hdr_err), 32'h1);
      do_reset();
      chk("R7 cleared by reset", 32'(hdr_err), 32'h0);

      // R5 wrap
      en = 1'b1;
      cfg(3'd4, 16'h0001);
      for (int i = 0; i < 65535; i++) begin
         put(1'b1, 4'd0, 32'h1);
         put(1'b0, 4'd1, 32'(i));
      end
      chk("R5 full scale", 32'(tick_cnt), 32'hFFFF);
      put(1'b1, 4'd0, 32'h1);
      put(1'b0, 4'd1, 32'hCAFE_0001);
      chk("R5 wrap to zero", 32'(tick_cnt), 32'h0);
      chk("R5 wrap tick", 32'(tick_irq), 32'h1);
      chk("R4 tcode at wrap", tcode, 32'hCAFE_0001);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule